// File: doc/BRIEF.md
# Instruction step-gating flow controller

This block sits between an instruction fetch unit and an instruction decoder. Each fetched word carries a wait flag in its most significant bit, above an opcode field and an operand field. When the flag is clear the instruction is accepted in the cycle it is offered. The controller acknowledges the fetch unit, enables the program counter and registers the opcode and operand for the decoder on the next clock edge.

When the flag is set the controller stops with the word in hand. It captures the word into a pending register and keeps its decoder outputs at the previous instruction. It then waits for a user to confirm on a debounced push-button. Confirmation requires a press seen during the wait, followed by the release of that press. The acknowledge and the program-counter enable go high in the cycle the release is first seen, and the captured instruction reaches the decoder on the following edge.

The block also produces a registered next-PC strobe. It is high in the cycle after the program counter was enabled while the decoder requested either a load or an increment.

Top module: `step_gate`

## Requirements
- R1: With no wait pending, `fetch_rdy` = 1 and `fetch_word[12]` = 0, `fetch_ack` and `pc_en` are both 1 in that same cycle.
- R2: With `fetch_word[12]` = 1 offered while no wait is pending, `fetch_ack` and `pc_en` stay 0 and `dec_op`/`dec_arg` keep their values for as long as the wait lasts. Changes on `fetch_word` during the wait have no effect. The word captured on arrival is the one later released.
- R3: During a wait, once a press has been seen, the first cycle in which the button reads released has `fetch_ack` = 1 and `pc_en` = 1. This is a pulse of exactly one cycle.
- R4: A button that is already pressed when the flagged word arrives does not confirm it when released. A new press followed by a release is required.
- R5: While the button stays pressed, the wait continues and `fetch_ack` stays 0.
- R6: With no wait pending and `fetch_rdy` = 0, `fetch_ack` and `pc_en` are 0.
- R7: `pc_new` equals (`pc_ld` OR `pc_inc`) AND `pc_en`, as sampled at the previous rising edge.
- R8: A synchronous reset (`rst` = 1) clears `dec_op`, `dec_arg` and `pc_new` to 0 and cancels a pending wait. After reset, an unflagged word is accepted at once.
- R9: Button presses and releases while no wait is pending have no effect on any output, and they do not pre-confirm a later flagged word.
- R10: On acceptance, `dec_op` takes `fetch_word[11:8]` and `dec_arg` takes `fetch_word[7:0]` on the next rising edge. For a confirmed word these are the captured word's fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| fetch_word | input | 13 | Fetched word: bit 12 wait flag, bits 11:8 opcode, bits 7:0 operand |
| fetch_rdy | input | 1 | Fetch unit offers a word |
| btn | input | 1 | Debounced confirm button, high while pressed (default polarity) |
| pc_ld | input | 1 | Decoder requests a program-counter load |
| pc_inc | input | 1 | Decoder requests a program-counter increment |
| dec_op | output | 4 | Held opcode toward the decoder |
| dec_arg | output | 8 | Held operand toward the decoder |
| pc_en | output | 1 | Program-counter enable, high in the accept cycle |
| fetch_ack | output | 1 | Acknowledge toward the fetch unit, high in the accept cycle |
| pc_new | output | 1 | Registered next-PC strobe |

## Verification
The bench sweeps every opcode across varied operands and load/increment combinations, in both unflagged and flagged form. Several corner cases are targeted. A design that confirmed on any release edge would accept a word when a button held before arrival is let go, and the held-on-arrival runs catch this. A design that read the bus at confirmation instead of capturing it would release the junk word the bench drives during the wait. A stretched or repeated acknowledge would show up in the cycle after confirmation. The bench also toggles the button while idle, which catches any pre-arming, and resets in the middle of a wait to show that the stall is cancelled.

// File: rtl/step_gate_pkg.sv
package step_gate_pkg;
   // Flow state of the controller: running freely or holding for the user.
   typedef enum logic {
      SG_RUN  = 1'b0,
      SG_HOLD = 1'b1
   } sg_state_e;
endpackage

// File: rtl/sg_button_edges.sv
module sg_button_edges #(
   parameter int BTN_ACTIVE_HIGH = 1
) (
   input  logic clk,
   input  logic rst,
   input  logic btn_i,
   output logic press_o,
   output logic release_o
);
   logic pressed_now;
   logic pressed_q;

   // Polarity variant: normalise to "pressed = 1".
   generate
      if (BTN_ACTIVE_HIGH != 0) begin : g_active_high
         assign pressed_now = btn_i;
      end else begin : g_active_low
         assign pressed_now = ~btn_i;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) pressed_q <= 1'b0;
      else     pressed_q <= pressed_now;
   end

   assign press_o   =  pressed_now & ~pressed_q;
   assign release_o = ~pressed_now &  pressed_q;
endmodule

// File: rtl/sg_flow_fsm.sv
module sg_flow_fsm
   import step_gate_pkg::*;
(
   input  logic clk,
   input  logic rst,
   input  logic fetch_rdy_i,
   input  logic wait_flag_i,
   input  logic press_i,
   input  logic release_i,
   output logic accept_o,
   output logic take_bus_o,
   output logic take_pend_o,
   output logic capture_o,
   output logic waiting_o
);
   sg_state_e state_q;
   logic      armed_q;

   always_comb begin
      capture_o   = (state_q == SG_RUN)  & fetch_rdy_i &  wait_flag_i;
      take_bus_o  = (state_q == SG_RUN)  & fetch_rdy_i & ~wait_flag_i;
      take_pend_o = (state_q == SG_HOLD) & armed_q & release_i;
      accept_o    = take_bus_o | take_pend_o;
      waiting_o   = (state_q == SG_HOLD);
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= SG_RUN;
      end else if (capture_o) begin
         state_q <= SG_HOLD;
      end else if (take_pend_o) begin
         state_q <= SG_RUN;
      end
   end

   // A press counts only when it begins inside the hold window.
   always_ff @(posedge clk) begin
      if (rst) begin
         armed_q <= 1'b0;
      end else if ((state_q != SG_HOLD) || take_pend_o) begin
         armed_q <= 1'b0;
      end else if (press_i) begin
         armed_q <= 1'b1;
      end
   end
endmodule

// File: rtl/sg_instr_hold.sv
module sg_instr_hold #(
   parameter int OP_W  = 4,
   parameter int ARG_W = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [OP_W-1:0]  op_i,
   input  logic [ARG_W-1:0] arg_i,
   input  logic             capture_i,
   input  logic             take_bus_i,
   input  logic             take_pend_i,
   output logic [OP_W-1:0]  op_o,
   output logic [ARG_W-1:0] arg_o
);
   logic [OP_W-1:0]  pend_op_q;
   logic [ARG_W-1:0] pend_arg_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         pend_op_q  <= '0;
         pend_arg_q <= '0;
      end else if (capture_i) begin
         pend_op_q  <= op_i;
         pend_arg_q <= arg_i;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         op_o  <= '0;
         arg_o <= '0;
      end else if (take_bus_i) begin
         op_o  <= op_i;
         arg_o <= arg_i;
      end else if (take_pend_i) begin
         op_o  <= pend_op_q;
         arg_o <= pend_arg_q;
      end
   end
endmodule

// File: rtl/sg_pc_strobe.sv
module sg_pc_strobe (
   input  logic clk,
   input  logic rst,
   input  logic pc_ld_i,
   input  logic pc_inc_i,
   input  logic pc_en_i,
   output logic pc_new_o
);
   always_ff @(posedge clk) begin
      if (rst) pc_new_o <= 1'b0;
      else     pc_new_o <= (pc_ld_i | pc_inc_i) & pc_en_i;
   end
endmodule

// File: rtl/step_gate.sv
module step_gate #(
   parameter int OP_W            = 4,
   parameter int ARG_W           = 8,
   parameter int BTN_ACTIVE_HIGH = 1,
   localparam int BODY_W   = OP_W + ARG_W,
   localparam int WORD_W   = BODY_W + 1,
   localparam int FLAG_BIT = BODY_W
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [WORD_W-1:0] fetch_word,
   input  logic              fetch_rdy,
   input  logic              btn,
   input  logic              pc_ld,
   input  logic              pc_inc,
   output logic [OP_W-1:0]   dec_op,
   output logic [ARG_W-1:0]  dec_arg,
   output logic              pc_en,
   output logic              fetch_ack,
   output logic              pc_new
);
   generate
      if (OP_W < 1 || ARG_W < 1) begin : g_bad_width
         $error("step_gate: OP_W and ARG_W must be at least 1");
      end
      if (BTN_ACTIVE_HIGH != 0 && BTN_ACTIVE_HIGH != 1) begin : g_bad_pol
         $error("step_gate: BTN_ACTIVE_HIGH must be 0 or 1");
      end
   endgenerate

   logic press_w, release_w;
   logic accept_w, take_bus_w, take_pend_w, capture_w, waiting_w;

   sg_button_edges #(.BTN_ACTIVE_HIGH(BTN_ACTIVE_HIGH)) u_edges (
      .clk       (clk),
      .rst       (rst),
      .btn_i     (btn),
      .press_o   (press_w),
      .release_o (release_w)
   );

   sg_flow_fsm u_fsm (
      .clk         (clk),
      .rst         (rst),
      .fetch_rdy_i (fetch_rdy),
      .wait_flag_i (fetch_word[FLAG_BIT]),
      .press_i     (press_w),
      .release_i   (release_w),
      .accept_o    (accept_w),
      .take_bus_o  (take_bus_w),
      .take_pend_o (take_pend_w),
      .capture_o   (capture_w),
      .waiting_o   (waiting_w)
   );

   sg_instr_hold #(.OP_W(OP_W), .ARG_W(ARG_W)) u_hold (
      .clk         (clk),
      .rst         (rst),
      .op_i        (fetch_word[BODY_W-1:ARG_W]),
      .arg_i       (fetch_word[ARG_W-1:0]),
      .capture_i   (capture_w),
      .take_bus_i  (take_bus_w),
      .take_pend_i (take_pend_w),
      .op_o        (dec_op),
      .arg_o       (dec_arg)
   );

   assign pc_en     = accept_w;
   assign fetch_ack = accept_w;

   sg_pc_strobe u_strobe (
      .clk      (clk),
      .rst      (rst),
      .pc_ld_i  (pc_ld),
      .pc_inc_i (pc_inc),
      .pc_en_i  (pc_en),
      .pc_new_o (pc_new)
   );
endmodule

// File: rtl/step_gate_chk.sv
module step_gate_chk #(
   parameter int OP_W            = 4,
   parameter int ARG_W           = 8,
   parameter int BTN_ACTIVE_HIGH = 1,
   localparam int BODY_W = OP_W + ARG_W
) (
   input logic              clk,
   input logic              rst,
   input logic [BODY_W:0]   fetch_word,
   input logic              fetch_rdy,
   input logic              btn,
   input logic              pc_ld,
   input logic              pc_inc,
   input logic [OP_W-1:0]   dec_op,
   input logic [ARG_W-1:0]  dec_arg,
   input logic              pc_en,
   input logic              fetch_ack,
   input logic              pc_new,
   input logic              waiting
);
   logic pressed;
   assign pressed = (BTN_ACTIVE_HIGH != 0) ? btn : ~btn;

   p_quiet_no_rdy_r6: assert property (@(posedge clk) disable iff (rst)
      (!fetch_rdy && !waiting) |-> (!fetch_ack && !pc_en));

   p_flag_blocks_r2: assert property (@(posedge clk) disable iff (rst)
      (fetch_rdy && fetch_word[BODY_W] && !waiting) |-> !fetch_ack);

   p_hold_stable_r2: assert property (@(posedge clk) disable iff (rst)
      !fetch_ack |=> ($stable(dec_op) && $stable(dec_arg)));

   p_load_fields_r10: assert property (@(posedge clk) disable iff (rst)
      (fetch_ack && !waiting) |=>
         (dec_op == $past(fetch_word[BODY_W-1:ARG_W]) && dec_arg == $past(fetch_word[ARG_W-1:0])));

   p_confirm_released_r3: assert property (@(posedge clk) disable iff (rst)
      (waiting && fetch_ack) |-> !pressed);

   p_confirm_after_press_r4: assert property (@(posedge clk) disable iff (rst)
      (waiting && fetch_ack) |-> $past(pressed));

   p_pc_strobe_r7: assert property (@(posedge clk) disable iff (rst)
      !rst |=> (pc_new == $past((pc_ld || pc_inc) && pc_en)));

   p_reset_clears_r8: assert property (@(posedge clk)
      $past(rst) |-> (dec_op == '0 && dec_arg == '0 && !pc_new && !waiting));
endmodule

bind step_gate step_gate_chk #(
   .OP_W(OP_W), .ARG_W(ARG_W), .BTN_ACTIVE_HIGH(BTN_ACTIVE_HIGH)
) u_chk (
   .clk(clk), .rst(rst), .fetch_word(fetch_word), .fetch_rdy(fetch_rdy),
   .btn(btn), .pc_ld(pc_ld), .pc_inc(pc_inc), .dec_op(dec_op),
   .dec_arg(dec_arg), .pc_en(pc_en), .fetch_ack(fetch_ack),
   .pc_new(pc_new), .waiting(waiting_w)
);

// File: tb/tb_step_gate.sv
module tb_step_gate;
   logic        clk = 1'b0;
   logic        rst;
   logic [12:0] fw;
   logic        rdy, btn, ld, inc;
   logic [3:0]  dec_op;
   logic [7:0]  dec_arg;
   logic        pc_en, fetch_ack, pc_new;

   int checks   = 0;
   int failures = 0;
   logic [3:0] exp_op;
   logic [7:0] exp_arg;

   step_gate dut (
      .clk(clk), .rst(rst), .fetch_word(fw), .fetch_rdy(rdy), .btn(btn),
      .pc_ld(ld), .pc_inc(inc), .dec_op(dec_op), .dec_arg(dec_arg),
      .pc_en(pc_en), .fetch_ack(fetch_ack), .pc_new(pc_new)
   );

   always #4 clk = ~clk;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic summary();
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
   endtask

   task automatic chk_hold(input string req);
      chk(req, 32'(dec_op), 32'(exp_op));
      chk(req, 32'(dec_arg), 32'(exp_arg));
   endtask

   task automatic run_plain(input logic [3:0] op, input logic [7:0] arg,
                            input logic ld_v, input logic inc_v);
      fw = {1'b0, op, arg}; rdy = 1'b1; ld = ld_v; inc = inc_v;
      #2;
      chk("R1 ack", 32'(fetch_ack), 32'd1);
      chk("R1 pc_en", 32'(pc_en), 32'd1);
      tick();
      rdy = 1'b0; fw = {1'b0, ~op, ~arg};
      exp_op = op; exp_arg = arg;
      chk_hold("R10 fields");
      chk("R7 strobe", 32'(pc_new), 32'(ld_v | inc_v));
      #2;
      chk("R6 idle ack", 32'(fetch_ack), 32'd0);
      tick();
      chk("R7 strobe gated", 32'(pc_new), 32'd0);
      ld = 1'b0; inc = 1'b0;
   endtask

   task automatic run_flagged(input logic [3:0] op, input logic [7:0] arg,
                              input int press_len, input bit held_on_arrival);
      if (held_on_arrival) begin
         btn = 1'b1;
         tick();
      end
      fw = {1'b1, op, arg}; rdy = 1'b1;
      #2;
      chk("R2 no ack", 32'(fetch_ack), 32'd0);
      chk("R2 no pc_en", 32'(pc_en), 32'd0);
      tick();
      fw = {1'b0, ~op, ~arg};
      chk_hold("R2 held");
      #2;
      chk("R2 bus ignored", 32'(fetch_ack), 32'd0);
      if (held_on_arrival) begin
         btn = 1'b0;
         #2;
         chk("R4 stale release", 32'(fetch_ack), 32'd0);
         tick();
         chk_hold("R4 held");
      end else begin
         tick();
      end
      btn = 1'b1;
      for (int k = 0; k < press_len; k++) begin
         #2;
         chk("R5 pressed", 32'(fetch_ack), 32'd0);
         tick();
      end
      chk_hold("R5 held");
      btn = 1'b0;
      #2;
      chk("R3 ack", 32'(fetch_ack), 32'd1);
      chk("R3 pc_en", 32'(pc_en), 32'd1);
      tick();
      rdy = 1'b0;
      exp_op = op; exp_arg = arg;
      chk_hold("R10 captured");
      #2;
      chk("R3 single pulse", 32'(fetch_ack), 32'd0);
      tick();
   endtask

   initial begin
      #(8 * 150000);
      failures++;
      $display("FAIL watchdog expired actual=hung expected=done");
      summary();
      $finish;
   end

   initial begin
      rst = 1'b1; fw = '0; rdy = 1'b0; btn = 1'b0; ld = 1'b0; inc = 1'b0;
      exp_op = '0; exp_arg = '0;
      tick(); tick(); tick();
      chk_hold("R8 reset fields");
      chk("R8 reset strobe", 32'(pc_new), 32'd0);
      rst = 1'b0;
      tick();

      // Button activity while running: nothing moves, no pre-arming (R9, R6).
      for (int k = 0; k < 6; k++) begin
         btn = k[0];
         #2;
         chk("R9 idle button", 32'(fetch_ack), 32'd0);
         chk("R6 idle en", 32'(pc_en), 32'd0);
         tick();
      end
      btn = 1'b0;
      tick();
      chk_hold("R9 outputs");

      // Unflagged sweep over all opcodes and strobe combinations.
      for (int i = 0; i < 32; i++) begin
         run_plain(4'(i), 8'((i * 37 + 5) & 255), i[0], i[1]);
      end

      // Flagged sweep, with and without a button held on arrival.
      for (int i = 0; i < 16; i++) begin
         run_flagged(4'(15 - i), 8'((i * 91 + 3) & 255), 1 + (i % 3), i[0]);
      end

      // Back-to-back unflagged words after confirmation.
      run_plain(4'h9, 8'h3c, 1'b1, 1'b1);

      // Reset in the middle of a wait (R8).
      fw = {1'b1, 4'h6, 8'h77}; rdy = 1'b1;
      tick();
      tick();
      btn = 1'b1;
      tick();
      rst = 1'b1; rdy = 1'b0; btn = 1'b0;
      tick(); tick();
      rst = 1'b0;
      exp_op = '0; exp_arg = '0;
      chk_hold("R8 wait reset fields");
      chk("R8 wait reset strobe", 32'(pc_new), 32'd0);
      tick();
      fw = {1'b0, 4'ha, 8'h5e}; rdy = 1'b1;
      #2;
      chk("R8 wait cancelled", 32'(fetch_ack), 32'd1);
      tick();
      rdy = 1'b0;
      exp_op = 4'ha; exp_arg = 8'h5e;
      chk_hold("R8 after reset");
      tick();

      summary();
      $finish;
   end
endmodule